// File: doc/BRIEF.md
# Bidirectional Handshake Port Controller

This block runs one 8-bit peripheral port that carries data both ways over a single shared bus. Each direction has its own handshake. On the input side, the peripheral drives the bus and pulls an active-low strobe. The bus value is caught in an input latch, and an input-full flag tells the CPU that a byte is waiting. On the output side, a CPU write fills an output latch and pulls an active-low output-full flag. The peripheral then pulls its active-low acknowledge to take the byte.

The port drives the shared bus only while acknowledge is low. At all other times the bus is released, so the peripheral can drive input data onto it. A single interrupt request combines two sources, each with its own enable bit: a byte that has arrived, and an output byte that has been taken. The enables change through a single-bit set/reset write. Bit index 4 selects the input enable and bit index 6 selects the output enable.

The CPU side is a set of one-cycle read and write pulses, with no address decode. The pad side is split into input, output and output-enable signals, for a tri-state pad cell outside the block. The strobe and acknowledge inputs are sampled on the rising clock edge.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, input-full is 0, output-full (active low) is 1, both interrupt enables are 0, the interrupt request is 0 and the pad output enable is 0.
- R2: While the strobe is low on a clock edge, the input latch takes the bus value and input-full becomes 1 on that edge. The latch keeps the value from the last edge with the strobe low, and the CPU read data always shows the latch.
- R3: A CPU read pulse clears input-full on the next edge, unless the strobe is low in the same cycle. In that case input-full stays 1.
- R4: A CPU write pulse loads the output latch and drives output-full low on that edge. The output latch changes only on a CPU write.
- R5: Acknowledge low on an edge sets output-full back to 1, unless a CPU write comes in the same cycle. In that case the write wins and output-full stays low.
- R6: The pad output enable is 1 exactly while acknowledge is low, with no clock delay, and the pad output always shows the output latch.
- R7: A set/reset write with bit index 4 loads the input enable with the written value, and bit index 6 loads the output enable. Writes with the other six indices change neither enable.
- R8: The interrupt request is 1 whenever the strobe is high, input-full is 1 and the input enable is 1.
- R9: A pending output flag sets on the edge where acknowledge is seen high after having been low, and clears on a CPU write. The interrupt request is also 1 whenever this flag is set, output-full is high and the output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_rd | input | 1 | One-cycle CPU read pulse |
| cpu_wr | input | 1 | One-cycle CPU write pulse |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Input latch contents |
| bsr_wr | input | 1 | Single-bit set/reset write pulse |
| bsr_sel | input | 3 | Bit index for the set/reset write |
| bsr_val | input | 1 | Value loaded by the set/reset write |
| pad_in | input | 8 | Shared bus value seen at the pads |
| pad_out | output | 8 | Value the port drives onto the bus |
| pad_oe | output | 1 | Pad output enable |
| stb_n | input | 1 | Input strobe, active low |
| ack_n | input | 1 | Output acknowledge, active low |
| ibf | output | 1 | Input-full flag |
| obf_n | output | 1 | Output-full flag, active low |
| intr | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle the flag updates that follow a strobe, read, write or acknowledge:

- input-full rising after a strobe, with the latched value matching the bus;
- input-full falling after a read;
- output-full falling after a write and rising after an acknowledge;
- the output latch holding steady between writes;
- the pending output flag being cleared by a write.

Only the bench scenarios can show the following:

- the collisions, where a read meets the strobe or a write meets the acknowledge;
- that the six unused set/reset indices leave both enables alone;
- that the interrupt request follows each enable.

The bench also sweeps every byte value through both data paths.

// File: rtl/bidir_hs_port.sv
module bidir_hs_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_rd,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic         bsr_wr,
  input  logic [2:0]   bsr_sel,
  input  logic         bsr_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic         pad_oe,
  input  logic         stb_n,
  input  logic         ack_n,
  output logic         ibf,
  output logic         obf_n,
  output logic         intr
);
  localparam logic [2:0] IN_EN_BIT  = 3'd4;
  localparam logic [2:0] OUT_EN_BIT = 3'd6;

  logic [W-1:0] in_lat, out_lat;
  logic         ibf_q, obf_nq, inte_in, inte_out, ack_q, out_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_lat <= '0;
      ibf_q  <= 1'b0;
    end else if (!stb_n) begin
      in_lat <= pad_in;
      ibf_q  <= 1'b1;
    end else if (cpu_rd) begin
      ibf_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_lat <= '0;
      obf_nq  <= 1'b1;
    end else if (cpu_wr) begin
      out_lat <= cpu_wdata;
      obf_nq  <= 1'b0;
    end else if (!ack_n) begin
      obf_nq  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b1;
      out_pend <= 1'b0;
    end else begin
      ack_q <= ack_n;
      if (cpu_wr)
        out_pend <= 1'b0;
      else if (!ack_q && ack_n)
        out_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inte_in  <= 1'b0;
      inte_out <= 1'b0;
    end else if (bsr_wr) begin
      if (bsr_sel == IN_EN_BIT)  inte_in  <= bsr_val;
      if (bsr_sel == OUT_EN_BIT) inte_out <= bsr_val;
    end
  end

  assign cpu_rdata = in_lat;
  assign pad_out   = out_lat;
  assign pad_oe    = ~ack_n;
  assign ibf       = ibf_q;
  assign obf_n     = obf_nq;
  assign intr      = (stb_n & ibf_q & inte_in) | (out_pend & obf_nq & inte_out);

  a_r2_strobe_captures: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n |=> (ibf && cpu_rdata == $past(pad_in)));
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && stb_n) |=> !ibf);
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !obf_n);
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(pad_out));
  a_r5_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !cpu_wr) |=> obf_n);
  a_r9_write_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !out_pend);
endmodule

// File: tb/bidir_hs_port_tb.sv
module bidir_hs_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_rd = 1'b0, cpu_wr = 1'b0, bsr_wr = 1'b0, bsr_val = 1'b0;
  logic [7:0] cpu_wdata = '0, pad_in = '0;
  logic [2:0] bsr_sel = '0;
  logic       stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] cpu_rdata, pad_out;
  logic       pad_oe, ibf, obf_n, intr;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_hs_port #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bsr_wr(bsr_wr),
    .bsr_sel(bsr_sel), .bsr_val(bsr_val), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .stb_n(stb_n), .ack_n(ack_n), .ibf(ibf), .obf_n(obf_n),
    .intr(intr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stb_n = 1'b1; ack_n = 1'b1; cpu_rd = 0; cpu_wr = 0; bsr_wr = 0;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic bsr(input logic [2:0] sel, input logic val);
    bsr_sel = sel; bsr_val = val; bsr_wr = 1'b1;
    step();
    bsr_wr = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] v);
    pad_in = v; stb_n = 1'b0;
    step();
    stb_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] v);
    cpu_wdata = v; cpu_wr = 1'b1;
    step();
    cpu_wr = 1'b0;
  endtask

  task automatic ack_pulse();
    ack_n = 1'b0;
    step();
    ack_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(); #1;
    check("R1 ibf", ibf, 0);
    check("R1 obf_n", obf_n, 1);
    check("R1 intr", intr, 0);
    check("R1 pad_oe", pad_oe, 0);

    for (int v = 0; v < 256; v++) begin
      strobe(8'(v)); #1;
      check("R2 ibf", ibf, 1);
      check("R2 data", cpu_rdata, v);
      cpu_rd = 1'b1; step(); cpu_rd = 1'b0; #1;
      check("R3 cleared", ibf, 0);
      wr(8'(v) ^ 8'hA5); #1;
      check("R4 obf_n", obf_n, 0);
      check("R6 released", pad_oe, 0);
      ack_n = 1'b0; #1;
      check("R6 drive", pad_oe, 1);
      check("R6 value", pad_out, (v ^ 8'hA5));
      step(); ack_n = 1'b1; #1;
      check("R5 emptied", obf_n, 1);
      check("R6 off", pad_oe, 0);
    end

    // R2: held strobe keeps last sampled value
    pad_in = 8'h11; stb_n = 1'b0; step(); pad_in = 8'h22; step(); pad_in = 8'h33; step();
    stb_n = 1'b1; pad_in = 8'h44; step(); #1;
    check("R2 last", cpu_rdata, 8'h33);
    // R3: read colliding with strobe
    cpu_rd = 1'b1; stb_n = 1'b0; step(); cpu_rd = 1'b0; stb_n = 1'b1; #1;
    check("R3 collide", ibf, 1);
    // R5: write colliding with acknowledge
    cpu_wdata = 8'h5A; cpu_wr = 1'b1; ack_n = 1'b0; step(); cpu_wr = 1'b0; ack_n = 1'b1; #1;
    check("R5 collide", obf_n, 0);
    check("R4 collide data", pad_out, 8'h5A);

    // R7/R8/R9: sweep every set/reset index
    for (int i = 0; i < 8; i++) begin
      do_reset();
      bsr(3'(i), 1'b1);
      strobe(8'h3C); #1;
      check("R8 in intr", intr, (i == 4) ? 1 : 0);
      cpu_rd = 1'b1; step(); cpu_rd = 1'b0; #1;
      check("R8 in intr off", intr, 0);
      wr(8'h77); ack_pulse(); #1;
      check("R9 out intr", intr, (i == 6) ? 1 : 0);
      bsr(3'(i), 1'b0); #1;
      check("R7 cleared", intr, 0);
    end

    // R9: write drops pending; rise needed to re-arm
    do_reset();
    bsr(3'd6, 1'b1);
    wr(8'h01); ack_pulse(); #1;
    check("R9 set", intr, 1);
    wr(8'h02); #1;
    check("R9 wr clears", intr, 0);
    ack_n = 1'b0; step(); step(); #1;
    check("R9 ack low", intr, 0);
    ack_n = 1'b1; step(); #1;
    check("R9 ack rise", intr, 1);
    // R8: strobe low masks input term
    bsr(3'd4, 1'b1); bsr(3'd6, 1'b0);
    pad_in = 8'h9; stb_n = 1'b0; step(); #1;
    check("R8 stb low", intr, 0);
    stb_n = 1'b1; #1;
    check("R8 stb high", intr, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule